// File: doc/BRIEF.md
# Dual-Hash L2 Bucket Indexer

This block turns a 60-bit lookup seed, made from a MAC address and a VLAN identifier, into the bucket indices of a two-half MAC learning table. It folds the seed into an 11-bit key in two different ways. The plain fold XORs all the 11-bit slices of the seed together. The rotating fold turns two of those slices by fixed amounts before it XORs them in. A 2-bit algorithm select picks, separately for each half, which key is used. The upper half sits 2048 buckets above the lower half, so the table has 4096 buckets of 4 entries each, 16384 entries in all.

A table walker steps a 3-bit probe position from 0 to 7 across one lookup. The block turns each position into a flat entry address. Positions 0 to 3 land in the lower-half bucket and positions 4 to 7 land in the upper-half bucket. All the arithmetic is combinational. An optional output register, enabled by default, captures a result whenever the input valid is high and raises the output valid one cycle later.

Top module: `l2_dual_hash_indexer`

## Requirements
- R1: With algorithm select bit 0 low, the lower bucket equals the XOR of seed slices [10:0], [21:11], [32:22], [43:33], [54:44] and the field [59:55] zero-extended to 11 bits, with bucket bit 11 at 0.
- R2: With algorithm select bit 0 high, the lower bucket equals the XOR of [10:0], [54:44] and [32:22] unchanged, [21:11] rotated left by 6 (its bit 0 lands at key bit 6), and [43:33] rotated left by 5 (its bit 0 lands at key bit 5).
- R3: Seed bits [59:55] enter the plain fold and have no effect on the rotating fold.
- R4: Algorithm select bit 1 picks the rotating fold (1) or the plain fold (0) for the upper bucket, independently of bit 0.
- R5: The upper bucket equals its selected key plus 2048, so its bit 11 is 1. The lower bucket's bit 11 is always 0.
- R6: For positions 0 to 3, the entry address is the lower bucket times 4 plus the position.
- R7: For positions 4 to 7, the entry address is the upper bucket times 4 plus (position minus 4).
- R8: With the output register present, the results and the output valid appear one clock after a cycle with input valid high. Outputs hold their values while input valid is low, and output valid then reads 0.
- R9: After reset, the output valid, both buckets and the entry address read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; the result is captured when high |
| seed | input | 60 | Lookup seed built from a MAC address and a VLAN identifier |
| alg_sel | input | 2 | Bit 0: lower-half algorithm; bit 1: upper-half algorithm (1 = rotating fold) |
| probe_pos | input | 3 | Probe position 0..7 across both halves |
| out_valid | output | 1 | Result valid |
| lo_bucket | output | 12 | Lower-half bucket index |
| hi_bucket | output | 12 | Upper-half bucket index |
| entry_addr | output | 14 | Flat entry address for the probe position |

## Verification
The clocked properties assume that in_valid is a known 0 or 1 on every clock edge after reset, and that reset is released away from a clock edge. The bench meets both conditions: it drives every input, including in_valid, on the falling clock edge, and it releases reset on a falling edge. The properties assume nothing about the seed values. Any seed, algorithm select or position is a legal request.

// File: rtl/l2_hash_pkg.sv
package l2_hash_pkg;
  localparam int SEED_W_D = 60;
  localparam int KEY_W_D  = 11;
  localparam int SLOT_W_D = 2;

  // left rotation by a fixed amount inside an 11-bit key
  function automatic logic [KEY_W_D-1:0] key_rotl(input logic [KEY_W_D-1:0] x, input int amt);
    logic [2*KEY_W_D-1:0] dbl;
    dbl = {x, x} << amt;
    return dbl[2*KEY_W_D-1 -: KEY_W_D];
  endfunction

  // rotation applied to each full slice by the rotating fold
  function automatic int slice_rot(input int idx);
    case (idx)
      1:       return 6;
      3:       return 5;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/idx_fold_plain.sv
module idx_fold_plain #(
  parameter int SEED_W = 60,
  parameter int KEY_W  = 11
) (
  input  logic [SEED_W-1:0] seed,
  output logic [KEY_W-1:0]  key
);
  localparam int NFULL = SEED_W / KEY_W;
  localparam int TAIL  = SEED_W % KEY_W;

  logic [KEY_W-1:0] part [NFULL+1];

  generate
    for (genvar c = 0; c < NFULL; c++) begin : g_slice
      assign part[c] = seed[c*KEY_W +: KEY_W];
    end
    if (TAIL > 0) begin : g_tail
      assign part[NFULL] = {{(KEY_W-TAIL){1'b0}}, seed[SEED_W-1 -: TAIL]};
    end else begin : g_notail
      assign part[NFULL] = '0;
    end
  endgenerate

  always_comb begin
    key = '0;
    for (int c = 0; c <= NFULL; c++) key = key ^ part[c];
  end
endmodule

// File: rtl/idx_fold_rot.sv
module idx_fold_rot
  import l2_hash_pkg::*;
#(
  parameter int SEED_W = 60,
  parameter int KEY_W  = 11
) (
  input  logic [SEED_W-1:0] seed,
  output logic [KEY_W-1:0]  key
);
  localparam int NFULL = SEED_W / KEY_W;

  logic [KEY_W-1:0] part [NFULL];

  generate
    for (genvar c = 0; c < NFULL; c++) begin : g_slice
      logic [KEY_W-1:0] raw;
      assign raw = seed[c*KEY_W +: KEY_W];
      if (slice_rot(c) == 0) begin : g_keep
        assign part[c] = raw;
      end else begin : g_turn
        assign part[c] = KEY_W'(key_rotl(KEY_W_D'(raw), slice_rot(c)));
      end
    end
  endgenerate

  // the partial top field is left out of this fold
  always_comb begin
    key = '0;
    for (int c = 0; c < NFULL; c++) key = key ^ part[c];
  end
endmodule

// File: rtl/idx_bucket_sel.sv
module idx_bucket_sel #(
  parameter int KEY_W  = 11,
  parameter int SLOT_W = 2,
  localparam int BKT_W  = KEY_W + 1,
  localparam int POS_W  = SLOT_W + 1,
  localparam int ADDR_W = BKT_W + SLOT_W
) (
  input  logic [KEY_W-1:0]  key_plain,
  input  logic [KEY_W-1:0]  key_rot,
  input  logic [1:0]        alg_sel,
  input  logic [POS_W-1:0]  pos,
  output logic [BKT_W-1:0]  lo_bkt,
  output logic [BKT_W-1:0]  hi_bkt,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [BKT_W-1:0] HALF_OFS = BKT_W'(1) << KEY_W;

  logic [KEY_W-1:0] lo_key, hi_key;
  logic             upper_half;

  assign lo_key     = alg_sel[0] ? key_rot : key_plain;
  assign hi_key     = alg_sel[1] ? key_rot : key_plain;
  assign lo_bkt     = BKT_W'(lo_key);
  assign hi_bkt     = BKT_W'(hi_key) + HALF_OFS;
  assign upper_half = pos[POS_W-1];
  assign addr       = {(upper_half ? hi_bkt : lo_bkt), pos[SLOT_W-1:0]};
endmodule

// File: rtl/l2_dual_hash_indexer.sv
module l2_dual_hash_indexer
  import l2_hash_pkg::*;
#(
  parameter int SEED_W  = SEED_W_D,
  parameter int KEY_W   = KEY_W_D,
  parameter int SLOT_W  = SLOT_W_D,
  parameter bit REG_OUT = 1'b1,
  localparam int BKT_W  = KEY_W + 1,
  localparam int POS_W  = SLOT_W + 1,
  localparam int ADDR_W = BKT_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SEED_W-1:0] seed,
  input  logic [1:0]        alg_sel,
  input  logic [POS_W-1:0]  probe_pos,
  output logic              out_valid,
  output logic [BKT_W-1:0]  lo_bucket,
  output logic [BKT_W-1:0]  hi_bucket,
  output logic [ADDR_W-1:0] entry_addr
);
  logic [KEY_W-1:0]  k_plain, k_rot;
  logic [BKT_W-1:0]  lo_c, hi_c;
  logic [ADDR_W-1:0] addr_c;

  idx_fold_plain #(.SEED_W(SEED_W), .KEY_W(KEY_W)) u_plain (
    .seed(seed), .key(k_plain));

  idx_fold_rot #(.SEED_W(SEED_W), .KEY_W(KEY_W)) u_rot (
    .seed(seed), .key(k_rot));

  idx_bucket_sel #(.KEY_W(KEY_W), .SLOT_W(SLOT_W)) u_sel (
    .key_plain(k_plain), .key_rot(k_rot), .alg_sel(alg_sel), .pos(probe_pos),
    .lo_bkt(lo_c), .hi_bkt(hi_c), .addr(addr_c));

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid  <= 1'b0;
          lo_bucket  <= '0;
          hi_bucket  <= '0;
          entry_addr <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            lo_bucket  <= lo_c;
            hi_bucket  <= hi_c;
            entry_addr <= addr_c;
          end
        end
      end

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
      AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(lo_bucket) && $stable(hi_bucket) && $stable(entry_addr))); // R8
      AST_HALF_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (hi_bucket[BKT_W-1] && !lo_bucket[BKT_W-1])); // R5
      AST_ADDR_IN_BUCKET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (entry_addr[ADDR_W-1:SLOT_W] == lo_bucket ||
                       entry_addr[ADDR_W-1:SLOT_W] == hi_bucket)); // R6
    end else begin : g_comb
      assign out_valid  = in_valid;
      assign lo_bucket  = lo_c;
      assign hi_bucket  = hi_c;
      assign entry_addr = addr_c;
    end
  endgenerate
endmodule

// File: tb/tb_l2_dual_hash_indexer.sv
module tb_l2_dual_hash_indexer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [59:0] seed = '0;
  logic [1:0]  alg_sel = '0;
  logic [2:0]  probe_pos = '0;
  logic        out_valid;
  logic [11:0] lo_bucket, hi_bucket;
  logic [13:0] entry_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  l2_dual_hash_indexer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .seed(seed), .alg_sel(alg_sel),
    .probe_pos(probe_pos), .out_valid(out_valid), .lo_bucket(lo_bucket),
    .hi_bucket(hi_bucket), .entry_addr(entry_addr));

  // seed, alg_sel, probe_pos
  localparam logic [64:0] VEC [8] = '{
    {60'h0123456789ABCDE, 2'b00, 3'd0},
    {60'hFEDCBA987654321, 2'b01, 3'd1},
    {60'hFFFFFFFFFFFFFFF, 2'b10, 3'd4},
    {60'hA5A5A5A5A5A5A5A, 2'b11, 3'd7},
    {60'h800000000000000, 2'b00, 3'd5},
    {60'h00000000007FF00, 2'b01, 3'd3},
    {60'h5555555555AAAAA, 2'b10, 3'd2},
    {60'h0F0F0F0F0F0F0F0, 2'b11, 3'd6}
  };

  // plain fold: seed bit i lands on key bit i mod 11
  function automatic logic [10:0] ref_plain(input logic [59:0] s);
    logic [10:0] k = '0;
    for (int i = 0; i < 60; i++) k[i % 11] ^= s[i];
    return k;
  endfunction

  // rotating fold: slice 1 bits move up by 6, slice 3 bits up by 5, top field dropped
  function automatic logic [10:0] ref_rot(input logic [59:0] s);
    logic [10:0] k = '0;
    for (int i = 0; i < 55; i++) begin
      int j = i % 11;
      int sl = i / 11;
      int d = (sl == 1) ? (j + 6) % 11 : (sl == 3) ? (j + 5) % 11 : j;
      k[d] ^= s[i];
    end
    return k;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one request; sampled on the falling edge after the capturing rising edge
  task automatic apply(input logic [59:0] s, input logic [1:0] a, input logic [2:0] p);
    @(negedge clk);
    seed = s; alg_sel = a; probe_pos = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_full(input logic [59:0] s, input logic [1:0] a, input logic [2:0] p);
    logic [11:0] lo_e, hi_e;
    logic [13:0] ad_e;
    lo_e = {1'b0, a[0] ? ref_rot(s) : ref_plain(s)};
    hi_e = 12'd2048 + {1'b0, a[1] ? ref_rot(s) : ref_plain(s)};
    ad_e = (p < 3'd4) ? lo_e * 4 + 14'(p) : hi_e * 4 + 14'(p - 3'd4);
    chk(a[0] ? "R2 lower bucket rotating fold" : "R1 lower bucket plain fold",
        16'(lo_bucket), 16'(lo_e));
    chk("R4 R5 upper bucket", 16'(hi_bucket), 16'(hi_e));
    chk((p < 3'd4) ? "R6 entry address lower half" : "R7 entry address upper half",
        16'(entry_addr), 16'(ad_e));
    chk("R8 valid one cycle later", 16'(out_valid), 16'd1);
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset out_valid", 16'(out_valid), 16'd0);
    chk("R9 reset lo_bucket", 16'(lo_bucket), 16'd0);
    chk("R9 reset hi_bucket", 16'(hi_bucket), 16'd0);
    chk("R9 reset entry_addr", 16'(entry_addr), 16'd0);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      apply(VEC[v][64:5], VEC[v][4:3], VEC[v][2:0]);
      check_full(VEC[v][64:5], VEC[v][4:3], VEC[v][2:0]);
    end

    // R3: top field counts in the plain fold only
    apply(60'h1 << 55, 2'b00, 3'd0);
    chk("R3 top field in plain fold", 16'(lo_bucket), 16'h001);
    apply(60'h1 << 55, 2'b11, 3'd4);
    chk("R3 top field ignored by rotating fold", 16'(lo_bucket), 16'h000);
    chk("R3 R5 upper bucket offset only", 16'(hi_bucket), 16'h800);
    chk("R7 address of first upper entry", 16'(entry_addr), 16'h2000);

    // R2: rotation positions
    apply(60'h1 << 11, 2'b01, 3'd0);
    chk("R2 slice [21:11] bit 0 to key bit 6", 16'(lo_bucket), 16'h040);
    apply(60'h1 << 33, 2'b01, 3'd3);
    chk("R2 slice [43:33] bit 0 to key bit 5", 16'(lo_bucket), 16'h020);
    chk("R6 lower address slot 3", 16'(entry_addr), 16'h083);

    // R4: independent per-half selection
    apply(60'h1 << 11, 2'b10, 3'd6);
    chk("R4 lower uses plain fold", 16'(lo_bucket), 16'h001);
    chk("R4 upper uses rotating fold", 16'(hi_bucket), 16'h840);
    chk("R7 upper address slot 2", 16'(entry_addr), 16'h2102);

    // R8: idle cycles hold results and drop valid
    @(negedge clk);
    seed = 60'hFFFF0000FFFF000; alg_sel = 2'b11; probe_pos = 3'd1;
    repeat (2) @(negedge clk);
    chk("R8 idle out_valid low", 16'(out_valid), 16'd0);
    chk("R8 idle lo_bucket held", 16'(lo_bucket), 16'h001);
    chk("R8 idle hi_bucket held", 16'(hi_bucket), 16'h840);
    chk("R8 idle entry_addr held", 16'(entry_addr), 16'h2102);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule